// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

The arbiter sits next to the execution unit of a small 16-bit processor. Each time an instruction retires, the execution unit strobes `insn_done` for one cycle. On that cycle the arbiter looks at the decoder's class flags for the retiring instruction, the current trap, interrupt-enable and overflow flags, the exception requests raised by that instruction, a latched non-maskable request and the maskable request line. It then decides whether an interrupt is entered, and with which vector.

One cycle after the boundary, a one-cycle `take` pulse comes out together with the chosen 8-bit `vector`. Clear strobes for the trap and interrupt-enable flags are raised in the same cycle. The processor then does the stacking and the vector-table fetch on its own. The arbiter never produces the invalid-opcode or escape-opcode vectors, because those opcodes simply retire as no-ops.

Requests from the two external sources are suppressed on some boundaries. Both are suppressed on the boundary of a stack-segment write or a prefix byte. Only the maskable request is suppressed on the boundary of an instruction that switched interrupt-enable from clear to set. In every one of these cases the suppressed request is served on the following boundary.

Top module: `irq_boundary_arbiter`

## Requirements
- R1: When a boundary (`insn_done`=1) selects a cause, `take`, `clr_tf` and `clr_ie` are all 1 for exactly the next clock cycle, and `vector` holds the chosen number during that cycle. With no cause selected, or with no boundary, all three stay 0.
- R2: Synchronous exceptions of the retiring instruction map to fixed vectors: divide error (`exc_div`) gives 0, breakpoint (`exc_brk`) gives 3, overflow trap (`exc_ovf_op` with `flag_of`=1) gives 4, and failed bounds check (`exc_bound`) gives 5. If several are raised together, the lowest vector number wins.
- R3: An overflow-trap instruction retiring with `flag_of`=0 raises nothing.
- R4: The priority at one boundary, from highest to lowest, is: synchronous exception, then non-maskable request, then maskable request, then single step.
- R5: A rising edge on `nmi_in` is latched at least one cycle before the boundary and delivers vector 2 exactly once. Holding `nmi_in` high does not raise it again. A latched request that loses arbitration stays pending.
- R6: `intr_in` is sampled as a level at the boundary and is taken only when `flag_ie`=1. The delivered vector is `ext_vec` as sampled on the boundary cycle.
- R7: On the boundary of an instruction flagged `cls_ss_write` or `cls_prefix`, neither the non-maskable nor the maskable request is taken. Each remains eligible at the next boundary.
- R8: On the boundary of an instruction flagged `cls_ie_rise`, the maskable request is not taken, but a pending non-maskable request is.
- R9: Single step (vector 1) is taken at a boundary where `flag_tf`=1, unless that instruction is flagged `cls_tf_write`.
- R10: Vectors 6 and 7 are never produced by internal causes. Every internal cause yields a vector in 0..5.
- R11: While `rst_n`=0, and after reset until the first selected boundary, `take`, `clr_tf`, `clr_ie` and `vector` are 0, and no non-maskable request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | One-cycle strobe: an instruction has fully retired |
| cls_ss_write | input | 1 | Retiring instruction wrote the stack segment |
| cls_prefix | input | 1 | Retiring instruction was a prefix byte |
| cls_ie_rise | input | 1 | Retiring instruction set interrupt-enable from a cleared state |
| cls_tf_write | input | 1 | Retiring instruction modified the trap flag |
| flag_tf | input | 1 | Trap flag |
| flag_ie | input | 1 | Interrupt-enable flag |
| flag_of | input | 1 | Overflow flag |
| exc_div | input | 1 | Divide error from the retiring instruction |
| exc_brk | input | 1 | Retiring instruction was the breakpoint instruction |
| exc_ovf_op | input | 1 | Retiring instruction was the overflow-trap instruction |
| exc_bound | input | 1 | Bounds check failed |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| intr_in | input | 1 | Maskable request, level-sensitive |
| ext_vec | input | 8 | Vector supplied with the maskable request |
| take | output | 1 | Interrupt entry pulse |
| vector | output | 8 | Vector number for the entry |
| clr_tf | output | 1 | Clear trap flag |
| clr_ie | output | 1 | Clear interrupt-enable flag |

## Verification
Every result of this block is due on the first clock edge after the boundary strobe. The decision is combinational on that cycle and goes through a single output register, so `take`, `vector` and the two clear strobes are valid during the cycle that follows. The driver raises `insn_done` on a falling edge and pushes one expected item for every boundary. The monitor pops that item on the next falling edge, which lies midway through the output cycle. A non-maskable edge needs one registered cycle to become pending, so the bench always leaves at least one idle cycle between raising `nmi_in` and the boundary that should serve it.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int VEC_W = 8;
  localparam int EXC_N = 4;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXC  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_EXT  = 3'd3,
    SRC_STEP = 3'd4
  } src_e;

  localparam logic [VEC_W-1:0] VEC_DIV   = 8'd0;
  localparam logic [VEC_W-1:0] VEC_STEP  = 8'd1;
  localparam logic [VEC_W-1:0] VEC_NMI   = 8'd2;
  localparam logic [VEC_W-1:0] VEC_BRK   = 8'd3;
  localparam logic [VEC_W-1:0] VEC_OVF   = 8'd4;
  localparam logic [VEC_W-1:0] VEC_BOUND = 8'd5;

  // Request slot i -> architectural vector; slots ordered by rising vector.
  function automatic logic [VEC_W-1:0] exc_slot_vec(input int i);
    case (i)
      0:       return VEC_DIV;
      1:       return VEC_BRK;
      2:       return VEC_OVF;
      default: return VEC_BOUND;
    endcase
  endfunction

  // Lowest slot wins: scan from the top so the last hit is the lowest one.
  function automatic logic [VEC_W-1:0] exc_first_vec(input logic [EXC_N-1:0] req);
    logic [VEC_W-1:0] v;
    v = VEC_DIV;
    for (int i = EXC_N - 1; i >= 0; i--) begin
      if (req[i]) v = exc_slot_vec(i);
    end
    return v;
  endfunction

endpackage

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic served,
  output logic pending,
  output logic edge_seen
);
  logic nmi_q;

  assign edge_seen = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      nmi_q   <= nmi_in;
      pending <= (pending & ~served) | edge_seen;
    end
  end
endmodule

// File: rtl/irqseq_gate.sv
module irqseq_gate (
  input  logic cls_ss_write,
  input  logic cls_prefix,
  input  logic cls_ie_rise,
  input  logic cls_tf_write,
  input  logic flag_tf,
  input  logic flag_ie,
  input  logic nmi_pending,
  input  logic intr_in,
  output logic hold_all,
  output logic nmi_ok,
  output logic ext_ok,
  output logic step_ok
);
  assign hold_all = cls_ss_write | cls_prefix;
  assign nmi_ok   = nmi_pending & ~hold_all;
  assign ext_ok   = intr_in & flag_ie & ~hold_all & ~cls_ie_rise;
  assign step_ok  = flag_tf & ~cls_tf_write;
endmodule

// File: rtl/irqseq_select.sv
module irqseq_select
  import irqseq_pkg::*;
(
  input  logic [EXC_N-1:0] exc_req,
  input  logic             nmi_ok,
  input  logic             ext_ok,
  input  logic             step_ok,
  input  logic [VEC_W-1:0] ext_vec,
  output src_e             src,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    src = SRC_NONE;
    vec = '0;
    if (|exc_req) begin
      src = SRC_EXC;
      vec = exc_first_vec(exc_req);
    end else if (nmi_ok) begin
      src = SRC_NMI;
      vec = VEC_NMI;
    end else if (ext_ok) begin
      src = SRC_EXT;
      vec = ext_vec;
    end else if (step_ok) begin
      src = SRC_STEP;
      vec = VEC_STEP;
    end
  end
endmodule

// File: rtl/irq_boundary_arbiter.sv
module irq_boundary_arbiter
  import irqseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_done,
  input  logic       cls_ss_write,
  input  logic       cls_prefix,
  input  logic       cls_ie_rise,
  input  logic       cls_tf_write,
  input  logic       flag_tf,
  input  logic       flag_ie,
  input  logic       flag_of,
  input  logic       exc_div,
  input  logic       exc_brk,
  input  logic       exc_ovf_op,
  input  logic       exc_bound,
  input  logic       nmi_in,
  input  logic       intr_in,
  input  logic [7:0] ext_vec,
  output logic       take,
  output logic [7:0] vector,
  output logic       clr_tf,
  output logic       clr_ie
);
  logic [EXC_N-1:0] exc_req;
  logic             nmi_pending;
  logic             nmi_edge;
  logic             nmi_served;
  logic             hold_all;
  logic             nmi_ok;
  logic             ext_ok;
  logic             step_ok;
  src_e             pick_src;
  logic [VEC_W-1:0] pick_vec;
  logic             entry;

  // Slot order must follow exc_slot_vec.
  assign exc_req = {exc_bound, exc_ovf_op & flag_of, exc_brk, exc_div};

  assign entry      = insn_done & (pick_src != SRC_NONE);
  assign nmi_served = insn_done & (pick_src == SRC_NMI);

  irqseq_nmi_latch u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_in    (nmi_in),
    .served    (nmi_served),
    .pending   (nmi_pending),
    .edge_seen (nmi_edge)
  );

  irqseq_gate u_gate (
    .cls_ss_write (cls_ss_write),
    .cls_prefix   (cls_prefix),
    .cls_ie_rise  (cls_ie_rise),
    .cls_tf_write (cls_tf_write),
    .flag_tf      (flag_tf),
    .flag_ie      (flag_ie),
    .nmi_pending  (nmi_pending),
    .intr_in      (intr_in),
    .hold_all     (hold_all),
    .nmi_ok       (nmi_ok),
    .ext_ok       (ext_ok),
    .step_ok      (step_ok)
  );

  irqseq_select u_sel (
    .exc_req (exc_req),
    .nmi_ok  (nmi_ok),
    .ext_ok  (ext_ok),
    .step_ok (step_ok),
    .ext_vec (ext_vec),
    .src     (pick_src),
    .vec     (pick_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take   <= 1'b0;
      clr_tf <= 1'b0;
      clr_ie <= 1'b0;
      vector <= '0;
    end else begin
      take   <= entry;
      clr_tf <= entry;
      clr_ie <= entry;
      if (entry) vector <= pick_vec;
    end
  end
endmodule

// File: rtl/irqseq_checker.sv
module irqseq_checker
  import irqseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic             cls_ss_write,
  input logic             cls_prefix,
  input logic             cls_ie_rise,
  input logic             cls_tf_write,
  input logic             flag_ie,
  input logic [EXC_N-1:0] exc_req,
  input logic             nmi_pending,
  input src_e             pick_src,
  input logic [VEC_W-1:0] pick_vec,
  input logic             take,
  input logic             clr_tf,
  input logic             clr_ie
);
  a_r1_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_done));
  a_r1_clears_with_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (clr_tf && clr_ie));
  a_r1_no_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (!clr_tf && !clr_ie));
  a_r4_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && (|exc_req)) |-> (pick_src == SRC_EXC));
  a_r5_nmi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pending && !(insn_done && pick_src == SRC_NMI)) |=> nmi_pending);
  a_r6_ie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !flag_ie) |-> (pick_src != SRC_EXT));
  a_r7_hold_both: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && (cls_ss_write || cls_prefix)) |->
      (pick_src != SRC_NMI && pick_src != SRC_EXT));
  a_r8_hold_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && cls_ie_rise) |-> (pick_src != SRC_EXT));
  a_r9_tf_write: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && cls_tf_write) |-> (pick_src != SRC_STEP));
  a_r10_internal_range: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && pick_src != SRC_NONE && pick_src != SRC_EXT) |-> (pick_vec <= 8'd5));
endmodule

bind irq_boundary_arbiter irqseq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_done    (insn_done),
  .cls_ss_write (cls_ss_write),
  .cls_prefix   (cls_prefix),
  .cls_ie_rise  (cls_ie_rise),
  .cls_tf_write (cls_tf_write),
  .flag_ie      (flag_ie),
  .exc_req      (exc_req),
  .nmi_pending  (nmi_pending),
  .pick_src     (pick_src),
  .pick_vec     (pick_vec),
  .take         (take),
  .clr_tf       (clr_tf),
  .clr_ie       (clr_ie)
);

// File: tb/test_irq_boundary_arbiter.sv
module test_irq_boundary_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 0, cls_ss_write = 0, cls_prefix = 0, cls_ie_rise = 0, cls_tf_write = 0;
  logic flag_tf = 0, flag_ie = 0, flag_of = 0;
  logic exc_div = 0, exc_brk = 0, exc_ovf_op = 0, exc_bound = 0;
  logic nmi_in = 0, intr_in = 0;
  logic [7:0] ext_vec = 8'h00;
  logic take, clr_tf, clr_ie;
  logic [7:0] vector;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    bit         t;
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];
  bit done_d = 0;

  always #10 clk = ~clk;

  irq_boundary_arbiter i_irq_boundary_arbiter (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
    .cls_ss_write(cls_ss_write), .cls_prefix(cls_prefix),
    .cls_ie_rise(cls_ie_rise), .cls_tf_write(cls_tf_write),
    .flag_tf(flag_tf), .flag_ie(flag_ie), .flag_of(flag_of),
    .exc_div(exc_div), .exc_brk(exc_brk), .exc_ovf_op(exc_ovf_op), .exc_bound(exc_bound),
    .nmi_in(nmi_in), .intr_in(intr_in), .ext_vec(ext_vec),
    .take(take), .vector(vector), .clr_tf(clr_tf), .clr_ie(clr_ie)
  );

  always @(posedge clk) done_d <= insn_done;

  // Monitor: one expected item per boundary, checked in the following cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_d) begin
        exp_t e;
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL %s: boundary with no expected item, actual take=%0b exp none", "R1", take);
        end else begin
          e = sb.pop_front();
          if (take !== e.t || clr_tf !== e.t || clr_ie !== e.t ||
              (e.t && vector !== e.v))
            begin
              n_fail++;
              $display("FAIL %s: actual take=%0b clr=%0b%0b vec=%0d, expected take=%0b vec=%0d",
                       e.tag, take, clr_tf, clr_ie, vector, e.t, e.v);
            end
        end
      end else if (take !== 1'b0 || clr_tf !== 1'b0 || clr_ie !== 1'b0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R1: pulse without boundary, actual take=%0b expected 0", take);
      end
    end
  end

  task automatic insn(input bit ssw, input bit pre, input bit ier, input bit tfw,
                      input bit dv, input bit bk, input bit ov, input bit bd,
                      input bit et, input logic [7:0] ev, input string tag);
    exp_t e;
    cls_ss_write = ssw; cls_prefix = pre; cls_ie_rise = ier; cls_tf_write = tfw;
    exc_div = dv; exc_brk = bk; exc_ovf_op = ov; exc_bound = bd;
    insn_done = 1'b1;
    e.t = et; e.v = ev; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    insn_done = 0; cls_ss_write = 0; cls_prefix = 0; cls_ie_rise = 0; cls_tf_write = 0;
    exc_div = 0; exc_brk = 0; exc_ovf_op = 0; exc_bound = 0;
    @(negedge clk);
  endtask

  task automatic plain(input bit et, input logic [7:0] ev, input string tag);
    insn(0, 0, 0, 0, 0, 0, 0, 0, et, ev, tag);
  endtask

  task automatic nmi_pulse();
    nmi_in = 1'b1;
    @(negedge clk);
    nmi_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (take !== 1'b0 || vector !== 8'd0 || clr_tf !== 1'b0 || clr_ie !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: reset take=%0b vec=%0d clr=%0b%0b expected 0 0 00", take, vector, clr_tf, clr_ie);
    end
    rst_n = 1'b1;
    @(negedge clk);
    plain(0, 0, "R11 no pending nmi after reset");
    plain(0, 0, "R1 idle boundary");

    insn(0,0,0,0, 1,0,0,0, 1, 8'd0, "R2 divide");
    insn(0,0,0,0, 0,1,0,0, 1, 8'd3, "R2 breakpoint");
    insn(0,0,0,0, 0,0,0,1, 1, 8'd5, "R2 bounds");
    flag_of = 1;
    insn(0,0,0,0, 0,0,1,0, 1, 8'd4, "R2 overflow trap");
    flag_of = 0;
    insn(0,0,0,0, 0,0,1,0, 0, 8'd0, "R3 overflow clear");
    insn(0,0,0,0, 0,1,0,1, 1, 8'd3, "R2 brk+bound lowest");
    flag_of = 1; flag_tf = 1;
    insn(0,0,0,1, 1,1,1,1, 1, 8'd0, "R10 all internal causes");
    flag_of = 0; flag_tf = 0;

    nmi_pulse();
    plain(1, 8'd2, "R5 nmi served");
    plain(0, 0, "R5 nmi served once");
    nmi_in = 1; @(negedge clk);
    plain(1, 8'd2, "R5 nmi level edge");
    plain(0, 0, "R5 held level no retrigger");
    nmi_in = 0; @(negedge clk);

    nmi_pulse();
    insn(0,0,0,0, 0,1,0,0, 1, 8'd3, "R4 exception over nmi");
    plain(1, 8'd2, "R5 nmi kept pending");

    flag_ie = 1; intr_in = 1; ext_vec = 8'h40;
    plain(1, 8'h40, "R6 maskable vector");
    flag_ie = 0;
    plain(0, 0, "R6 ie clear masks");
    flag_ie = 1; flag_tf = 1; ext_vec = 8'h77;
    plain(1, 8'h77, "R4 maskable over step");
    nmi_pulse();
    plain(1, 8'd2, "R4 nmi over maskable");
    intr_in = 0;
    plain(1, 8'd1, "R9 single step");
    insn(0,0,0,1, 0,0,0,0, 0, 8'd0, "R9 tf write suppresses");
    flag_tf = 0;

    intr_in = 1; ext_vec = 8'h21;
    insn(0,1,0,0, 0,0,0,0, 0, 8'd0, "R7 prefix holds maskable");
    plain(1, 8'h21, "R7 maskable after prefix");
    intr_in = 0;
    nmi_pulse();
    insn(1,0,0,0, 0,0,0,0, 0, 8'd0, "R7 ss write holds nmi");
    plain(1, 8'd2, "R7 nmi after ss write");

    intr_in = 1; ext_vec = 8'h08;
    insn(0,0,1,0, 0,0,0,0, 0, 8'd0, "R8 ie rise holds maskable");
    plain(1, 8'h08, "R8 maskable next boundary");
    nmi_pulse();
    insn(0,0,1,0, 0,0,0,0, 1, 8'd2, "R8 nmi not held");
    intr_in = 0; flag_ie = 0;

    repeat (3) @(negedge clk);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d expected entries never checked, expected 0", sb.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1: watchdog expired, actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule